// File: doc/BRIEF.md
# Input delay window calibration controller

This controller centres one shared input-delay setting inside the data valid window of a source-synchronous bus. A copy of the incoming clock runs through a private calibration delay line whose tap the controller drives on `cal_tap`. A flip-flop clocked by the buffered incoming clock captures that delayed copy and returns one bit on `sample_in`. That bit is the only feedback the controller receives.

The controller sweeps the calibration tap upward from zero. After each tap change it waits for the line to settle. It then takes a reading only when several consecutive samples agree, which rejects metastable captures. It records the two taps where the captured bit changes and drives their rounded-down midpoint as one common tap value to every data-bit delay line. The data delays change only at that single update and never during a search, so live bus capture is not disturbed.

A sweep is launched by `start`. With `continuous` held high the controller repeats the search after an idle interval, indefinitely, and rewrites the data tap only when the new centre differs from the current one.

Top module: `dlycal_top`

## Requirements
- R1: A synchronous active-high reset sets `cal_tap` and `data_tap` (and every copy on `data_tap_bus`) to 0, and sets `data_tap_valid`, `busy`, `done` and `error` to 0.
- R2: A `start` seen while idle launches a sweep. `cal_tap` goes to 0 and afterwards only ever steps up by one or returns to 0. `busy` is 1 while the sweep runs.
- R3: At each tap the controller waits SETTLE_CYC cycles, then accepts a reading only after STABLE_N identical consecutive samples. A sample that toggles while the line settles must not register as an edge.
- R4: The reading at tap 0 is the reference. Edge A is the first tap whose accepted reading differs from the reference. Edge B is the next tap whose reading differs from the reading at A, whichever way it changes.
- R5: The centre is (A + B) >> 1, rounded down. The same value appears on `data_tap` and on all BUS_W TAP_W-bit copies of `data_tap_bus`.
- R6: `data_tap` changes only when a centre is applied, and `data_tap_valid` is high for exactly that one cycle. It is held for the whole sweep.
- R7: In one-shot mode (`continuous` = 0), a successful sweep applies the centre (always pulsing `data_tap_valid`), sets `done` = 1 and clears `busy`. The controller then stays idle. A new `start` clears `done`.
- R8: An edge B found at the last tap (TAPS-1) counts as a success.
- R9: If the last tap is reached without both edges, `error` is set and stays set until reset. `data_tap` keeps its previous value, no `data_tap_valid` pulse occurs, and `done` stays 0.
- R10: With `continuous` = 1, a new sweep starts IDLE_CYC cycles after each one ends. A centre equal to the current `data_tap` produces no update and no pulse.
- R11: Lowering `continuous` during the idle interval returns the controller to idle. No further sweep starts until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a sweep when idle |
| continuous | input | 1 | 1 = repeat sweeps after the idle interval |
| sample_in | input | 1 | Captured bit from the calibration flip-flop |
| cal_tap | output | TAP_W | Tap code for the calibration delay line |
| data_tap | output | TAP_W | Common tap code for the data delay lines |
| data_tap_bus | output | BUS_W*TAP_W | One copy of the data tap per bus bit |
| data_tap_valid | output | 1 | One-cycle pulse when data_tap is rewritten |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | A centre has been applied since the last start |
| error | output | 1 | Sticky: a sweep ended without two edges |

## Verification
Two things can coincide in one cycle. The second edge can be accepted at the very tap where the sweep would otherwise declare failure for running out of range. The bench provokes this with a window whose closing edge sits on tap TAPS-1, and requires a valid centre with `error` still low. It also places the only edge on the last tap and requires the failure path, with `data_tap` unchanged and no pulse. In continuous mode, a recomputed centre can meet an unchanged `data_tap`. The bench judges this by counting `data_tap_valid` pulses across two full sweeps of an unchanged window and expecting none.

// File: rtl/dlycal_pkg.sv
package dlycal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SAMPLE,
    ST_APPLY,
    ST_REST
  } cal_state_e;

endpackage

// File: rtl/dlycal_timer.sv
module dlycal_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dlycal_filter.sv
module dlycal_filter #(
  parameter int STABLE_N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic bit_in,
  output logic acc_vld,
  output logic acc_val
);

  localparam int CW = (STABLE_N < 2) ? 1 : $clog2(STABLE_N);
  localparam logic [CW-1:0] NEED = CW'(STABLE_N - 1);

  logic          seen_q;
  logic          cand_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seen_q <= 1'b0;
      cand_q <= 1'b0;
      run_q  <= '0;
    end else if (en) begin
      if (!seen_q || bit_in != cand_q) begin
        seen_q <= 1'b1;
        cand_q <= bit_in;
        run_q  <= CW'(1);
      end else if (run_q != NEED) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign acc_vld = en && seen_q && (bit_in == cand_q) && (run_q == NEED);
  assign acc_val = cand_q;

  // R3: an accepted reading never follows a differing sample
  a_r3_stable_accept: assert property (@(posedge clk) disable iff (rst)
    acc_vld |-> (bit_in == $past(bit_in)));

endmodule

// File: rtl/dlycal_fanout.sv
module dlycal_fanout #(
  parameter int TAP_W = 6,
  parameter int BUS_W = 16
) (
  input  logic [TAP_W-1:0]       tap_in,
  output logic [BUS_W*TAP_W-1:0] tap_bus
);

  for (genvar g = 0; g < BUS_W; g++) begin : g_copy
    assign tap_bus[g*TAP_W +: TAP_W] = tap_in;
  end

endmodule

// File: rtl/dlycal_top.sv
module dlycal_top
  import dlycal_pkg::*;
#(
  parameter int TAPS       = 64,
  parameter int BUS_W      = 16,
  parameter int SETTLE_CYC = 8,
  parameter int STABLE_N   = 4,
  parameter int IDLE_CYC   = 32,
  localparam int TAP_W     = $clog2(TAPS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   continuous,
  input  logic                   sample_in,
  output logic [TAP_W-1:0]       cal_tap,
  output logic [TAP_W-1:0]       data_tap,
  output logic [BUS_W*TAP_W-1:0] data_tap_bus,
  output logic                   data_tap_valid,
  output logic                   busy,
  output logic                   done,
  output logic                   error
);

  localparam int TMR_MAX = (SETTLE_CYC > IDLE_CYC) ? SETTLE_CYC : IDLE_CYC;
  localparam int CNT_W   = $clog2(TMR_MAX + 1);
  localparam logic [TAP_W-1:0] TAP_MAX  = TAP_W'(TAPS - 1);
  localparam logic [CNT_W-1:0] T_SETTLE = CNT_W'(SETTLE_CYC);
  localparam logic [CNT_W-1:0] T_REST   = CNT_W'(IDLE_CYC);

  cal_state_e       state_q, state_n;
  logic [TAP_W-1:0] cal_tap_q, tap_n;
  logic [TAP_W-1:0] data_tap_q;
  logic [TAP_W-1:0] edge_a_q, edge_b_q;
  logic             have_ref_q, ref_val_q, got_a_q;
  logic             valid_q, busy_q, done_q, err_q;

  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             acc_vld, acc_val;
  logic             take_ref, take_a, take_b, fail, adv, sweep_go;
  logic [TAP_W:0]   edge_sum;
  logic [TAP_W-1:0] centre;

  dlycal_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  dlycal_filter #(.STABLE_N(STABLE_N)) u_filter (
    .clk     (clk),
    .rst     (rst),
    .clr     (state_q != ST_SAMPLE),
    .en      (state_q == ST_SAMPLE),
    .bit_in  (sample_in),
    .acc_vld (acc_vld),
    .acc_val (acc_val)
  );

  dlycal_fanout #(.TAP_W(TAP_W), .BUS_W(BUS_W)) u_fanout (
    .tap_in  (data_tap_q),
    .tap_bus (data_tap_bus)
  );

  assign edge_sum = {1'b0, edge_a_q} + {1'b0, edge_b_q};
  assign centre   = edge_sum[TAP_W:1];

  always_comb begin
    state_n  = state_q;
    tap_n    = cal_tap_q;
    tmr_load = 1'b0;
    tmr_val  = T_SETTLE;
    take_ref = 1'b0;
    take_a   = 1'b0;
    take_b   = 1'b0;
    adv      = 1'b0;
    fail     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n  = ST_SETTLE;
          tap_n    = '0;
          tmr_load = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_done) state_n = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (acc_vld) begin
          if (!have_ref_q) begin
            take_ref = 1'b1;
            adv      = 1'b1;
          end else if (acc_val != ref_val_q) begin
            if (!got_a_q) begin
              take_a = 1'b1;
              adv    = 1'b1;
            end else begin
              take_b  = 1'b1;
              state_n = ST_APPLY;
            end
          end else begin
            adv = 1'b1;
          end
          if (adv) begin
            if (cal_tap_q == TAP_MAX) begin
              fail     = 1'b1;
              state_n  = continuous ? ST_REST : ST_IDLE;
              tmr_load = continuous;
              tmr_val  = T_REST;
            end else begin
              tap_n    = cal_tap_q + 1'b1;
              state_n  = ST_SETTLE;
              tmr_load = 1'b1;
            end
          end
        end
      end
      ST_APPLY: begin
        state_n  = continuous ? ST_REST : ST_IDLE;
        tmr_load = continuous;
        tmr_val  = T_REST;
      end
      ST_REST: begin
        if (!continuous) begin
          state_n = ST_IDLE;
        end else if (tmr_done) begin
          state_n  = ST_SETTLE;
          tap_n    = '0;
          tmr_load = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign sweep_go = (state_n == ST_SETTLE) &&
                    (state_q == ST_IDLE || state_q == ST_REST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cal_tap_q  <= '0;
      data_tap_q <= '0;
      edge_a_q   <= '0;
      edge_b_q   <= '0;
      have_ref_q <= 1'b0;
      ref_val_q  <= 1'b0;
      got_a_q    <= 1'b0;
      valid_q    <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q   <= state_n;
      cal_tap_q <= tap_n;
      valid_q   <= 1'b0;
      busy_q    <= (state_n == ST_SETTLE) || (state_n == ST_SAMPLE) ||
                   (state_n == ST_APPLY);
      if (sweep_go) begin
        have_ref_q <= 1'b0;
        got_a_q    <= 1'b0;
        if (state_q == ST_IDLE) done_q <= 1'b0;
      end
      if (take_ref) begin
        have_ref_q <= 1'b1;
        ref_val_q  <= acc_val;
      end
      if (take_a) begin
        got_a_q   <= 1'b1;
        edge_a_q  <= cal_tap_q;
        ref_val_q <= acc_val;
      end
      if (take_b) edge_b_q <= cal_tap_q;
      if (fail) err_q <= 1'b1;
      if (state_q == ST_APPLY) begin
        done_q <= 1'b1;
        if (!continuous || centre != data_tap_q) begin
          data_tap_q <= centre;
          valid_q    <= 1'b1;
        end
      end
    end
  end

  assign cal_tap        = cal_tap_q;
  assign data_tap       = data_tap_q;
  assign data_tap_valid = valid_q;
  assign busy           = busy_q;
  assign done           = done_q;
  assign error          = err_q;

  // R6: every change of the data tap is flagged
  a_r6_change_flagged: assert property (@(posedge clk) disable iff (rst)
    (data_tap_q != $past(data_tap_q)) |-> valid_q);

  // R6: the update flag is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

  // R9: raising the error never moves the data tap
  a_r9_fail_keeps_tap: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $stable(data_tap_q));

  // R2: calibration tap steps by one or restarts at zero
  a_r2_tap_step: assert property (@(posedge clk) disable iff (rst)
    (cal_tap_q != $past(cal_tap_q)) |->
      ((cal_tap_q == $past(cal_tap_q) + 1'b1) || (cal_tap_q == '0)));

  // R9: the error flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(err_q) |-> err_q);

endmodule

// File: tb/tb_dlycal_top.sv
module tb_dlycal_top;

  localparam int TAPS  = 64;
  localparam int BUS_W = 16;
  localparam int TAP_W = $clog2(TAPS);
  localparam int NV    = 8;

  // window open tap, close tap, polarity, noisy tap, run fails, expected centre
  localparam int V_EA  [NV] = '{12,  3, 20, 10,  1, 63, 99,  5};
  localparam int V_EB  [NV] = '{40,  4, 51, 63, 62, 99, 99,  9};
  localparam int V_POL [NV] = '{ 0,  1,  0,  1,  0,  0,  1,  0};
  localparam int V_NT  [NV] = '{99, 99,  8, 99, 30, 99, 99, 99};
  localparam int V_FAIL[NV] = '{ 0,  0,  0,  0,  0,  1,  1,  0};
  localparam int V_EXP [NV] = '{26,  3, 35, 36, 31, 31, 31,  7};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic continuous = 1'b0;
  logic sample_in = 1'b0;
  logic [TAP_W-1:0]       cal_tap, data_tap;
  logic [BUS_W*TAP_W-1:0] data_tap_bus;
  logic data_tap_valid, busy, done, error;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int cycles = 0;
  int ea = 99, eb = 99, pol = 0, nt = 99;
  int age = 0;
  logic [TAP_W-1:0] prev_tap = '0;

  always #5 clk = ~clk;

  dlycal_top #(.TAPS(TAPS), .BUS_W(BUS_W)) dut (
    .clk(clk), .rst(rst), .start(start), .continuous(continuous),
    .sample_in(sample_in), .cal_tap(cal_tap), .data_tap(data_tap),
    .data_tap_bus(data_tap_bus), .data_tap_valid(data_tap_valid),
    .busy(busy), .done(done), .error(error)
  );

  function automatic logic win(int t);
    return logic'(pol) ^ logic'((t >= ea) && (t < eb));
  endfunction

  // capture flop model with a toggling burst at the noisy tap
  always @(posedge clk) begin
    prev_tap <= cal_tap;
    age <= (cal_tap != prev_tap) ? 0 : age + 1;
    if (int'(cal_tap) == nt && age < 16) sample_in <= win(int'(cal_tap)) ^ logic'(age[0]);
    else sample_in <= win(int'(cal_tap));
  end

  always @(negedge clk) if (data_tap_valid) pulses <= pulses + 1;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_check(input string req);
    logic same = 1'b1;
    for (int i = 0; i < BUS_W; i++)
      if (data_tap_bus[i*TAP_W +: TAP_W] != data_tap) same = 1'b0;
    check(same, req, int'(same), 1);
  endtask

  task automatic wait_busy(input logic lvl);
    int n = 0;
    while (busy !== lvl && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    int err_seen = 0;
    int p0;
    int busy_hits;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(cal_tap == 0 && data_tap == 0, "R1 taps after reset", int'(data_tap), 0);
    check(!busy && !done && !error && !data_tap_valid, "R1 flags after reset",
          int'({busy, done, error, data_tap_valid}), 0);
    bus_check("R1 bus copies zero");

    // one-shot vector table: R2 R3 R4 R5 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      ea = V_EA[v]; eb = V_EB[v]; pol = V_POL[v]; nt = V_NT[v];
      p0 = pulses;
      pulse_start();
      @(negedge clk);
      check(busy == 1'b1, "R2 busy during sweep", int'(busy), 1);
      wait_busy(1'b0);
      @(negedge clk);
      if (V_FAIL[v] != 0) err_seen = 1;
      check(int'(data_tap) == V_EXP[v], "R5 centre (R4 R3 R8 R9)", int'(data_tap), V_EXP[v]);
      check(int'(error) == err_seen, "R9 error flag", int'(error), err_seen);
      check(int'(done) == 1 - V_FAIL[v], "R7 done", int'(done), 1 - V_FAIL[v]);
      check(pulses - p0 == 1 - V_FAIL[v], "R6 update pulses", pulses - p0, 1 - V_FAIL[v]);
      bus_check("R5 bus copies");
    end

    // R1: reset in the middle of a sweep
    ea = 12; eb = 40; pol = 0; nt = 99;
    pulse_start();
    repeat (100) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cal_tap == 0 && data_tap == 0 && !busy && !error && !done,
          "R1 mid-sweep reset", int'(cal_tap), 0);

    // R10: continuous mode
    continuous = 1'b1;
    p0 = pulses;
    pulse_start();
    while (pulses == p0) @(negedge clk);
    check(int'(data_tap) == 26, "R10 first continuous centre", int'(data_tap), 26);
    ea = 30; eb = 50;
    p0 = pulses;
    while (pulses == p0) @(negedge clk);
    check(int'(data_tap) == 40, "R10 tracked window change", int'(data_tap), 40);
    p0 = pulses;
    for (int k = 0; k < 2; k++) begin
      wait_busy(1'b1);
      wait_busy(1'b0);
    end
    @(negedge clk);
    check(pulses == p0, "R10 no update for equal centre", pulses - p0, 0);
    check(int'(data_tap) == 40 && done, "R10 tap held", int'(data_tap), 40);

    // R11: leaving continuous mode during the idle interval
    continuous = 1'b0;
    busy_hits = 0;
    repeat (150) begin
      @(negedge clk);
      if (busy) busy_hits++;
    end
    check(busy_hits == 0, "R11 no sweep after leaving continuous", busy_hits, 0);
    check(int'(data_tap) == 40, "R11 tap kept", int'(data_tap), 40);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule